// File: doc/BRIEF.md
# Split-Address Dual-Byte Video Memory Adapter

A video processor may address its memory as two independent 8-bit planes, each with its own word address. Lane A reaches the low-byte plane and lane B the high-byte plane. This adapter puts both planes in one 16-bit-wide memory that has a single read address per cycle. The memory is always read at the lane A address. When the two lane addresses agree, that one word serves both lanes: the low byte goes to lane A and the high byte to lane B. When they differ, as happens while a rotated or scaled background fetches a map entry and a pixel colour in the same cycle, lane A still gets a fresh low byte. Lane B gets a held copy of the high byte from the last agreeing read, and the `lane_b_stale` output is raised for that cycle.

Lane B's data source is a two-state machine, `src_e`, in `laneb_hold`. The states are:
- `SRC_MEMORY`: lane B takes the high byte of the fetched word. This is the reset state.
- `SRC_HOLD`: lane B takes the held byte.

The transitions are checked every clock:
- `t_agree` goes to `SRC_MEMORY` when the presented addresses are equal.
- `t_diverge` goes to `SRC_HOLD` when they differ.

The held byte is reloaded only while the machine is in `SRC_MEMORY`. A shared write port updates either byte of a word under byte enables. A debug read port views the same storage as single bytes.

Top module: `split_vram_adapter`

## Requirements
- R1: While `rst_n` is low, `lane_a_data`, `lane_b_data`, `dbg_data` and `lane_b_stale` are all 0.
- R2: If `lane_a_addr` equals `lane_b_addr` in a cycle, then in the next cycle `lane_a_data` is bits 7:0 and `lane_b_data` is bits 15:8 of that word, and `lane_b_stale` is 0.
- R3: If the two lane addresses differ in a cycle, then in the next cycle `lane_a_data` is bits 7:0 of the word at `lane_a_addr`, `lane_b_data` is the held byte, and `lane_b_stale` is 1.
- R4: The held byte is the `lane_b_data` value of the most recent cycle whose read had equal addresses. A run of diverging reads keeps `lane_b_data` constant.
- R5: Read data appears exactly one clock after its address. Before that edge the outputs still show the previous result.
- R6: On a write, `wr_be[0]` enables bits 7:0 and `wr_be[1]` enables bits 15:8 of word `wr_addr`. A disabled byte keeps its old value.
- R7: A read of a word that is written in the same cycle returns the word's old contents. The new contents are returned from the next cycle on.
- R8: Byte address `dbg_addr` selects word `dbg_addr >> 1`: bit 0 equal to 0 selects the low byte and 1 the high byte. `dbg_data` shows that byte one clock later.
- R9: After reset, until the first read with equal addresses, a diverging read returns 0x00 on lane B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lane_a_addr | input | AW | Word address of lane A (low-byte plane) |
| lane_b_addr | input | AW | Word address of lane B (high-byte plane) |
| lane_a_data | output | 8 | Lane A read byte |
| lane_b_data | output | 8 | Lane B read byte |
| lane_b_stale | output | 1 | Lane B byte came from the held copy |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write word address |
| wr_data | input | 16 | Write word |
| wr_be | input | 2 | Byte enables, bit 0 for the low byte |
| dbg_addr | input | AW+1 | Debug byte address |
| dbg_data | output | 8 | Debug read byte |

## Verification
The bench builds the adapter with AW = 6, which gives 64 words and 128 bytes. At that size every word can be filled with a known pattern in a few cycles. The last word and the last byte address can then be read at both ends of the range, and a reference copy of the whole memory fits in the bench. The structure is the same as the full-size setting of AW = 15, because only the address width changes.

// File: rtl/vadp_pkg.sv
package vadp_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned LANES  = 2;
    localparam int unsigned WORD_W = BYTE_W * LANES;

    typedef enum logic {
        SRC_MEMORY = 1'b0,
        SRC_HOLD   = 1'b1
    } src_e;
endpackage

// File: rtl/vram_store.sv
module vram_store
    import vadp_pkg::*;
#(
    parameter int unsigned AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_word,
    input  logic [AW:0]       dbg_addr,
    output logic [BYTE_W-1:0] dbg_byte
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [BYTE_W-1:0] dbg_lane [LANES];
    logic              dbg_sel_q;

    // one byte plane per lane; reads sample before the write lands
    for (genvar g = 0; g < LANES; g++) begin : g_plane
        logic [BYTE_W-1:0] plane [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_be[g]) begin
                plane[wr_addr] <= wr_data[g*BYTE_W +: BYTE_W];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rd_word[g*BYTE_W +: BYTE_W] <= '0;
                dbg_lane[g]                 <= '0;
            end else begin
                rd_word[g*BYTE_W +: BYTE_W] <= plane[rd_addr];
                dbg_lane[g]                 <= plane[dbg_addr[AW:1]];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dbg_sel_q <= 1'b0;
        end else begin
            dbg_sel_q <= dbg_addr[0];
        end
    end

    assign dbg_byte = dbg_lane[dbg_sel_q];

    // R8: debug view of a low byte agrees with the word read path
    p_dbg_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_addr[0] == 1'b0 && dbg_addr[AW:1] == rd_addr)
        |=> (dbg_byte == rd_word[BYTE_W-1:0]));
endmodule

// File: rtl/laneb_hold.sv
module laneb_hold
    import vadp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              same_addr,
    input  logic [WORD_W-1:0] word_q,
    output logic [BYTE_W-1:0] lane_a,
    output logic [BYTE_W-1:0] lane_b,
    output logic              from_hold
);
    src_e              state_q;
    src_e              state_d;
    logic [BYTE_W-1:0] hold_q;

    // transitions t_agree / t_diverge
    always_comb begin
        state_d = same_addr ? SRC_MEMORY : SRC_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SRC_MEMORY;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SRC_MEMORY) begin
                hold_q <= word_q[WORD_W-1:BYTE_W];
            end
        end
    end

    always_comb begin
        lane_a = word_q[BYTE_W-1:0];
        unique case (state_q)
            SRC_MEMORY: begin
                lane_b    = word_q[WORD_W-1:BYTE_W];
                from_hold = 1'b0;
            end
            SRC_HOLD: begin
                lane_b    = hold_q;
                from_hold = 1'b1;
            end
            default: begin
                lane_b    = '0;
                from_hold = 1'b0;
            end
        endcase
    end

    // R4: consecutive held cycles keep lane B steady
    p_hold_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (from_hold && $past(from_hold)) |-> $stable(lane_b));
endmodule

// File: rtl/split_vram_adapter.sv
module split_vram_adapter
    import vadp_pkg::*;
#(
    parameter int unsigned AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] lane_a_addr,
    input  logic [AW-1:0] lane_b_addr,
    output logic [7:0]    lane_a_data,
    output logic [7:0]    lane_b_data,
    output logic          lane_b_stale,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [15:0]   wr_data,
    input  logic [1:0]    wr_be,
    input  logic [AW:0]   dbg_addr,
    output logic [7:0]    dbg_data
);
    logic [WORD_W-1:0] word_q;
    logic              same_addr;

    assign same_addr = (lane_a_addr == lane_b_addr);

    vram_store #(.AW(AW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_be    (wr_be),
        .rd_addr  (lane_a_addr),
        .rd_word  (word_q),
        .dbg_addr (dbg_addr),
        .dbg_byte (dbg_data)
    );

    laneb_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .same_addr (same_addr),
        .word_q    (word_q),
        .lane_a    (lane_a_data),
        .lane_b    (lane_b_data),
        .from_hold (lane_b_stale)
    );

    // R3: diverging addresses give a held lane B next cycle
    p_split_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_a_addr != lane_b_addr) |=> lane_b_stale);

    // R2: agreeing addresses give a fresh lane B next cycle
    p_joint_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_a_addr == lane_b_addr) |=> !lane_b_stale);

    // R4: the first held cycle repeats the last fresh lane B byte
    p_enter_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lane_b_stale) |-> (lane_b_data == $past(lane_b_data)));
endmodule

// File: tb/sim_split_vram_adapter.sv
module sim_split_vram_adapter;
    localparam int unsigned AW = 6;
    localparam int unsigned NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] lane_a_addr = '0, lane_b_addr = '0, wr_addr = '0;
    logic [7:0]    lane_a_data, lane_b_data, dbg_data;
    logic          lane_b_stale, wr_en = 1'b0;
    logic [15:0]   wr_data = '0;
    logic [1:0]    wr_be = '0;
    logic [AW:0]   dbg_addr = '0;

    int checks = 0;
    int fails  = 0;
    logic [15:0] mem_m [NW];
    logic [7:0]  hold_m = 8'h00;

    always #2 clk = ~clk;

    split_vram_adapter #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .lane_a_addr(lane_a_addr), .lane_b_addr(lane_b_addr),
        .lane_a_data(lane_a_data), .lane_b_data(lane_b_data),
        .lane_b_stale(lane_b_stale),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .dbg_addr(dbg_addr), .dbg_data(dbg_data)
    );

    task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one read/write cycle against the reference model
    task automatic step(input int a, input int b, input bit we, input int wa,
                        input logic [15:0] wd, input logic [1:0] be,
                        input int dba, input bit chk, input string tag);
        logic [7:0] ea, eb, ed;
        bit joint;
        lane_a_addr = AW'(a); lane_b_addr = AW'(b);
        wr_en = we; wr_addr = AW'(wa); wr_data = wd; wr_be = be;
        dbg_addr = (AW+1)'(dba);
        joint = (a == b);
        ea = mem_m[a][7:0];
        eb = joint ? mem_m[a][15:8] : hold_m;
        ed = dba[0] ? mem_m[dba >> 1][15:8] : mem_m[dba >> 1][7:0];
        @(posedge clk); #1;
        if (chk) begin
            check(tag, "lane_a", 16'(lane_a_data), 16'(ea));
            check(tag, "lane_b", 16'(lane_b_data), 16'(eb));
            check(tag, "stale", 16'(lane_b_stale), 16'(!joint));
            check("R8", "dbg", 16'(dbg_data), 16'(ed));
        end
        if (we) begin
            if (be[0]) mem_m[wa][7:0]  = wd[7:0];
            if (be[1]) mem_m[wa][15:8] = wd[15:8];
        end
        if (joint) hold_m = eb;
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "lane_a", 16'(lane_a_data), 16'h0);
        check("R1", "lane_b", 16'(lane_b_data), 16'h0);
        check("R1", "dbg", 16'(dbg_data), 16'h0);
        check("R1", "stale", 16'(lane_b_stale), 16'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_fill;
        for (int w = 0; w < int'(NW); w++)
            step(0, 1, 1'b1, w, 16'(w * 16'h0305 + 16'h1A27), 2'b11, 0, 1'b0, "");
        step(0, 1, 1'b0, 0, 16'h0, 2'b00, 0, 1'b0, "");
    endtask

    task automatic t_hold_zero;   // R9
        step(5, 9, 1'b0, 0, 16'h0, 2'b00, 10, 1'b1, "R9");
        step(7, 2, 1'b0, 0, 16'h0, 2'b00, 11, 1'b1, "R9");
    endtask

    task automatic t_joint;       // R2
        step(0, 0, 1'b0, 0, 16'h0, 2'b00, 1, 1'b1, "R2");
        step(NW-1, NW-1, 1'b0, 0, 16'h0, 2'b00, 2*NW-1, 1'b1, "R2");
        step(17, 17, 1'b0, 0, 16'h0, 2'b00, 34, 1'b1, "R2");
    endtask

    task automatic t_latency;     // R5
        logic [7:0] prev;
        step(3, 3, 1'b0, 0, 16'h0, 2'b00, 0, 1'b1, "R5");
        prev = lane_a_data;
        lane_a_addr = AW'(40); lane_b_addr = AW'(40);
        #1;
        check("R5", "before edge", 16'(lane_a_data), 16'(prev));
        step(40, 40, 1'b0, 0, 16'h0, 2'b00, 80, 1'b1, "R5");
    endtask

    task automatic t_split;       // R3, R4
        step(10, 10, 1'b0, 0, 16'h0, 2'b00, 0, 1'b1, "R4");
        step(20, 30, 1'b0, 0, 16'h0, 2'b00, 41, 1'b1, "R3");
        step(40, 50, 1'b0, 0, 16'h0, 2'b00, 60, 1'b1, "R4");
        step(NW-1, 0, 1'b0, 0, 16'h0, 2'b00, 3, 1'b1, "R3");
        step(22, 22, 1'b0, 0, 16'h0, 2'b00, 0, 1'b1, "R4");
        step(9, 8, 1'b0, 0, 16'h0, 2'b00, 0, 1'b1, "R4");
    endtask

    task automatic t_byte_en;     // R6
        step(1, 2, 1'b1, 7, 16'hBEEF, 2'b01, 0, 1'b0, "");
        step(7, 7, 1'b0, 0, 16'h0, 2'b00, 15, 1'b1, "R6");
        step(1, 2, 1'b1, 7, 16'hC0DE, 2'b10, 0, 1'b0, "");
        step(7, 7, 1'b0, 0, 16'h0, 2'b00, 14, 1'b1, "R6");
        step(1, 2, 1'b1, 7, 16'h5555, 2'b00, 0, 1'b0, "");
        step(7, 7, 1'b0, 0, 16'h0, 2'b00, 15, 1'b1, "R6");
    endtask

    task automatic t_collide;     // R7
        step(12, 12, 1'b1, 12, 16'hA5C3, 2'b11, 24, 1'b1, "R7");
        step(12, 12, 1'b0, 0, 16'h0, 2'b00, 25, 1'b1, "R7");
    endtask

    task automatic t_debug;       // R8
        for (int k = 0; k < 6; k++)
            step(4, 5, 1'b0, 0, 16'h0, 2'b00, 2*NW - 1 - 13*k, 1'b1, "R8");
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int w = 0; w < int'(NW); w++) mem_m[w] = 'x;
        t_reset();
        t_fill();
        t_hold_zero();
        t_joint();
        t_latency();
        t_split();
        t_byte_en();
        t_collide();
        t_debug();
        summary();
    end
endmodule